// File: doc/BRIEF.md
# Serial Max/Min Stream Router

This block takes two unsigned operands that arrive one bit per clock, most significant bit first. It sends them out again on two serial lines with the same bit timing. The line `geBit` carries whichever operand is greater than or equal to the other, and `ltBit` carries the other operand. The outputs are combinational in the current input bits and the stored order, so there is no added latency. Bit k of a word leaves in the same cycle that it arrives.

The caller pulses `startIn` together with the first (most significant) bit of each word pair. Word length is therefore whatever spacing the caller gives between start pulses.

While the two words have matched so far, both bits are identical and the routing does not matter. At the first position where the bits differ, the block routes the operand holding the 1 to `geBit`. It keeps that routing until the next start pulse. Words that never differ leave with A on `geBit` and B on `ltBit`.

Top module: `serial_maxmin_router`

## Requirements
- R1: After reset, before any start pulse, the block behaves as at the start of a word: the first cycle with `aBit`=1, `bBit`=0 gives `geBit`=1, `ltBit`=0, and the following bits keep A on `geBit`.
- R2: While all bits of the current word have matched so far and the current bits are equal, `geBit` and `ltBit` both equal that bit.
- R3: In the cycle of the first differing bit of a word, `geBit`=1 and `ltBit`=0, with no cycle of delay.
- R4: After a word's first difference had `aBit`=1, every later bit of that word gives `geBit`=`aBit` and `ltBit`=`bBit`, whatever the later bit values.
- R5: After a word's first difference had `bBit`=1, every later bit of that word gives `geBit`=`bBit` and `ltBit`=`aBit`, whatever the later bit values.
- R6: A cycle with `startIn`=1 discards the previous word's order before its own bits are evaluated. A word that begins with equal bits gives `geBit`=`ltBit`=that bit, even right after a decided word.
- R7: When the two words are identical, `geBit` carries A and `ltBit` carries B for the whole word.
- R8: In every cycle, {`geBit`, `ltBit`} is a permutation of {`aBit`, `bBit`}. Read over a whole word, the `geBit` word is the maximum of the two operands and the `ltBit` word is the minimum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | High with the most significant bit of a new word pair |
| aBit | input | 1 | Current bit of operand A |
| bBit | input | 1 | Current bit of operand B |
| geBit | output | 1 | Current bit of the larger (or equal) operand |
| ltBit | output | 1 | Current bit of the smaller operand |

## Verification
A wrong stored order does not show while the remaining bits of the two words agree. It shows at the first later bit where A and B differ in the same word: both outputs swap, and the words read back as minimum on `geBit` and maximum on `ltBit`. A start pulse that fails to clear the order shows only if the new word's first difference favours the other operand. For that reason the stimulus alternates winners between back-to-back words and places the first difference at the top bit, at the bottom bit, and nowhere.

// File: rtl/sm_router_pkg.sv
package sm_router_pkg;

  typedef enum logic [1:0] {
    ORD_EQUAL = 2'd0,
    ORD_A_BIG = 2'd1,
    ORD_B_BIG = 2'd2
  } order_e;

  typedef struct packed {
    logic swapOut;
  } route_strobe_t;

endpackage

// File: rtl/sm_router_ctrl.sv
module sm_router_ctrl
  import sm_router_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          startIn,
  input  logic          aBit,
  input  logic          bBit,
  output route_strobe_t strobe
);

  order_e orderQ;
  order_e orderNow;
  order_e orderD;

  // a start pulse wipes the old word's order before this bit is judged
  always_comb orderNow = startIn ? ORD_EQUAL : orderQ;

  always_comb begin
    orderD = orderNow;
    if (orderNow == ORD_EQUAL && (aBit != bBit)) begin
      orderD = aBit ? ORD_A_BIG : ORD_B_BIG;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) orderQ <= ORD_EQUAL;
    else       orderQ <= orderD;
  end

  always_comb strobe.swapOut = (orderD == ORD_B_BIG);

endmodule

// File: rtl/sm_router_dp.sv
module sm_router_dp
  import sm_router_pkg::*;
(
  input  logic          aBit,
  input  logic          bBit,
  input  route_strobe_t strobe,
  output logic          geBit,
  output logic          ltBit
);

  always_comb begin
    geBit = strobe.swapOut ? bBit : aBit;
    ltBit = strobe.swapOut ? aBit : bBit;
  end

endmodule

// File: rtl/serial_maxmin_router.sv
module serial_maxmin_router
  import sm_router_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic startIn,
  input  logic aBit,
  input  logic bBit,
  output logic geBit,
  output logic ltBit
);

  route_strobe_t strobe;

  sm_router_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startIn),
    .aBit    (aBit),
    .bBit    (bBit),
    .strobe  (strobe)
  );

  sm_router_dp uDp (
    .aBit   (aBit),
    .bBit   (bBit),
    .strobe (strobe),
    .geBit  (geBit),
    .ltBit  (ltBit)
  );

endmodule

// File: rtl/serial_maxmin_router_chk.sv
module serial_maxmin_router_chk (
  input logic clk,
  input logic rstN,
  input logic startIn,
  input logic aBit,
  input logic bBit,
  input logic geBit,
  input logic ltBit
);

  // order as seen at the ports: set at a word's first differing bit
  logic seenDiff;
  logic seenB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenDiff <= 1'b0;
      seenB    <= 1'b0;
    end else if (startIn || !seenDiff) begin
      seenDiff <= (aBit != bBit);
      seenB    <= bBit & ~aBit;
    end
  end

  assert_permutation_R8: assert property (@(posedge clk) disable iff (!rstN)
    (32'(geBit) + 32'(ltBit)) == (32'(aBit) + 32'(bBit)));

  assert_equal_bits_R2: assert property (@(posedge clk) disable iff (!rstN)
    (aBit == bBit) |-> (geBit == aBit && ltBit == aBit));

  assert_first_diff_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!startIn && !seenDiff && aBit != bBit) |-> (geBit && !ltBit));

  assert_start_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && aBit != bBit) |-> (geBit && !ltBit));

  assert_sticky_a_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!startIn && seenDiff && !seenB) |-> (geBit == aBit && ltBit == bBit));

  assert_sticky_b_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!startIn && seenDiff && seenB) |-> (geBit == bBit && ltBit == aBit));

endmodule

bind serial_maxmin_router serial_maxmin_router_chk uChk (
  .clk     (clk),
  .rstN    (rstN),
  .startIn (startIn),
  .aBit    (aBit),
  .bBit    (bBit),
  .geBit   (geBit),
  .ltBit   (ltBit)
);

// File: tb/serial_maxmin_router_test.sv
module serial_maxmin_router_test;

  localparam int MaxLen = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0;
  logic aBit = 1'b0;
  logic bBit = 1'b0;
  logic geBit;
  logic ltBit;

  int checks = 0;
  int fails  = 0;
  int seed   = 32'h5eed;

  always #2 clk = ~clk;

  serial_maxmin_router uut (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startIn),
    .aBit    (aBit),
    .bBit    (bBit),
    .geBit   (geBit),
    .ltBit   (ltBit)
  );

  function automatic logic [MaxLen-1:0] maxOf(input logic [MaxLen-1:0] x, input logic [MaxLen-1:0] y);
    return (x >= y) ? x : y;
  endfunction

  function automatic logic [MaxLen-1:0] minOf(input logic [MaxLen-1:0] x, input logic [MaxLen-1:0] y);
    return (x >= y) ? y : x;
  endfunction

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // drive one word pair of len bits, MSB first, start on the first bit
  task automatic runWord(input logic [MaxLen-1:0] wa, input logic [MaxLen-1:0] wb, input int len);
    logic [MaxLen-1:0] hi = maxOf(wa, wb);
    logic [MaxLen-1:0] lo = minOf(wa, wb);
    logic [MaxLen-1:0] gotGe = '0;
    logic [MaxLen-1:0] gotLt = '0;
    bit differed = 0;
    string req;
    for (int i = len - 1; i >= 0; i--) begin
      @(posedge clk);
      #1;
      startIn = (i == len - 1);
      aBit = wa[i];
      bBit = wb[i];
      #1;
      if (!differed && wa[i] == wb[i]) req = (i == len - 1) ? "R6" : "R2";
      else if (!differed) req = "R3";
      else if (wa == wb) req = "R7";
      else req = (wa > wb) ? "R4" : "R5";
      if (wa == wb) req = (i == len - 1) ? req : "R7";
      check(req, geBit, hi[i], "geBit");
      check(req, ltBit, lo[i], "ltBit");
      gotGe[i] = geBit;
      gotLt[i] = ltBit;
      if (wa[i] != wb[i]) differed = 1;
    end
    checks++;
    if (gotGe != hi || gotLt != lo) begin
      fails++;
      $display("FAIL R8 word: actual %h/%h expected %h/%h", gotGe, gotLt, hi, lo);
    end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1: no start after reset, first difference favours A then holds
    @(posedge clk); #1 aBit = 1'b1; bBit = 1'b0; #1;
    check("R1", geBit, 1'b1, "geBit reset word");
    check("R1", ltBit, 1'b0, "ltBit reset word");
    @(posedge clk); #1 aBit = 1'b0; bBit = 1'b1; #1;
    check("R1", geBit, 1'b0, "geBit reset hold");
    check("R1", ltBit, 1'b1, "ltBit reset hold");
    // directed corners
    runWord(12'h0A5, 12'h0A5, 8);   // R7 identical
    runWord(12'h080, 12'h07F, 8);   // differs at MSB, A wins, R4
    runWord(12'h07F, 12'h080, 8);   // B wins right after, R6 + R5
    runWord(12'h054, 12'h055, 8);   // differs at LSB, R5
    runWord(12'h001, 12'h000, 1);   // one-bit word
    runWord(12'h0FF, 12'h000, 8);   // A wins first bit
    runWord(12'h000, 12'h000, 4);   // all zero equal words
    runWord(12'hFFF, 12'hFFE, 12);
    runWord(12'h3C0, 12'h3C0, 10);  // equal first bits after decided word, R6
    // random words, alternating lengths
    for (int n = 0; n < 400; n++) begin
      int len = 1 + int'($urandom % MaxLen);
      logic [MaxLen-1:0] msk = (MaxLen'(1) << len) - 1'b1;
      logic [MaxLen-1:0] wa = MaxLen'($urandom) & msk;
      logic [MaxLen-1:0] wb = MaxLen'($urandom) & msk;
      if ($urandom % 4 == 0) wb = wa ^ (MaxLen'(1) << ($urandom % len));
      runWord(wa, wb, len);
    end
    @(posedge clk);
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule